// File: doc/BRIEF.md
# Hierarchical Interrupt Status Aggregator

This block is the top-level interrupt status register of a storage-interface controller. When the interrupt line rises, the CPU reads this 8-bit register first to learn which group raised it. Four sticky event bits capture completions from a command sequencer, a DMA engine and an auto-sequence engine. Software clears these bits by writing back the value it read. Two summary bits mirror the pending state of two lower-level status registers, and one busy bit only reports that a command is running.

Two small state machines give meaning to the raw pulses. The command machine has states `CMD_IDLE` and `CMD_EXEC`, with transitions T_START (`CMD_IDLE`→`CMD_EXEC` on a start pulse), T_DONE (`CMD_EXEC`→`CMD_IDLE` on a done pulse) and T_ABORT (`CMD_EXEC`→`CMD_IDLE` on an abort-command or attention pulse; it has priority over T_DONE). The DMA machine has states `DMA_IDLE` and `DMA_RUN`, with transitions D_GO (`DMA_IDLE`→`DMA_RUN` on a go pulse) and D_END (`DMA_RUN`→`DMA_IDLE` on a normal end, a software stop, an abort-command pulse or an attention pulse). Every D_END sets the DMA-complete bit.

An enable mask register gates the sources onto a single interrupt line. Both registers share one write port, and a select input picks between them.

Top module: `irq_status_hub`

## Requirements
- R1: While reset is asserted and right after it, `status_o` reads 00h, `mask_o` reads 00h and `irq_o` is 0.
- R2: A `cmd_start_p` pulse in `CMD_EXEC`'s absence sets status bit 5 (executing) from the next cycle. A `cmd_done_p` pulse while executing sets bit 7 (normal completion) and clears bit 5 at the same edge.
- R3: An `abort_cmd_p` or `atn_p` pulse while executing sets bit 6 (aborted) and clears bit 5. If done and abort arrive together, only bit 6 is set.
- R4: While a DMA runs, a `dma_end_p`, `dma_stop_p`, `abort_cmd_p` or `atn_p` pulse sets bit 1 (DMA complete). These pulses do nothing while no DMA runs.
- R5: An `auto_done_p` pulse sets bit 0 (auto-sequence complete) only while `auto_en` is high.
- R6: Bit 4 equals `sub1_pend` and bit 3 equals `sub2_pend` in the same cycle, with no register in between.
- R7: A status write (`wr_en`=1, `wr_sel`=0) clears each of bits 7, 6, 1 and 0 where `wr_data` has a 1, from the next cycle. A 0 leaves the bit unchanged.
- R8: If a set event and a clearing write hit the same sticky bit in one cycle, the bit stays 1.
- R9: Status writes do not change bits 5, 4 and 3. Bit 2 always reads 0.
- R10: A mask write (`wr_en`=1, `wr_sel`=1) loads `wr_data` into `mask_o` from the next cycle.
- R11: `irq_o` is the OR of status AND mask over bits 7, 6, 4, 3, 1 and 0, in the same cycle. Bit 5 never drives `irq_o`, even when its mask bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_start_p | input | 1 | Control command begins (pulse) |
| cmd_done_p | input | 1 | Control command finished normally (pulse) |
| abort_cmd_p | input | 1 | Abort command issued (pulse) |
| atn_p | input | 1 | Attention asserted on the bus (pulse) |
| dma_go_p | input | 1 | DMA transfer started (pulse) |
| dma_end_p | input | 1 | DMA transfer count reached (pulse) |
| dma_stop_p | input | 1 | Software cleared the DMA go control (pulse) |
| auto_en | input | 1 | An auto-sequence mode is enabled |
| auto_done_p | input | 1 | Auto-sequence finished (pulse) |
| sub1_pend | input | 1 | Subordinate register 1 has a pending source |
| sub2_pend | input | 1 | Subordinate register 2 has a pending source |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects status, 1 selects mask |
| wr_data | input | 8 | Write data |
| status_o | output | 8 | Readable status register |
| mask_o | output | 8 | Readable enable mask |
| irq_o | output | 1 | Interrupt line to the CPU |

## Verification
Event pulses, status writes and mask writes take effect at the first rising edge after they are driven, because each passes through exactly one register. The summary bits and `irq_o` follow their inputs in the same cycle, since they are purely combinational. The bench changes inputs just after a falling edge. It checks registered results at the next falling edge, after exactly one rising edge. It checks combinational results one time step after it drives the input, before any edge.

// File: rtl/irqh_pkg.sv
package irqh_pkg;
    localparam int REG_W   = 8;
    localparam int N_STICK = 4;
    localparam int B_DONE  = 7;
    localparam int B_ABORT = 6;
    localparam int B_BUSY  = 5;
    localparam int B_SUB1  = 4;
    localparam int B_SUB2  = 3;
    localparam int B_RSVD  = 2;
    localparam int B_DMA   = 1;
    localparam int B_AUTO  = 0;
    localparam logic [REG_W-1:0] IRQ_SRC = 8'b1101_1011;

    typedef enum logic {CMD_IDLE = 1'b0, CMD_EXEC = 1'b1} cmd_state_t;
    typedef enum logic {DMA_IDLE = 1'b0, DMA_RUN  = 1'b1} dma_state_t;
endpackage

// File: rtl/irqh_cmd_fsm.sv
module irqh_cmd_fsm
    import irqh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_p,
    input  logic done_p,
    input  logic abort_p,
    input  logic atn_p,
    output logic busy,
    output logic done_evt,
    output logic abort_evt
);
    cmd_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CMD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMD_IDLE: if (start_p) state_d = CMD_EXEC;
            CMD_EXEC: if (abort_p || atn_p || done_p) state_d = CMD_IDLE;
        endcase
    end

    always_comb begin
        busy      = 1'b0;
        done_evt  = 1'b0;
        abort_evt = 1'b0;
        unique case (state_q)
            CMD_IDLE: ;
            CMD_EXEC: begin
                busy      = 1'b1;
                abort_evt = abort_p || atn_p;
                done_evt  = done_p && !(abort_p || atn_p);
            end
        endcase
    end
endmodule

// File: rtl/irqh_dma_fsm.sv
module irqh_dma_fsm
    import irqh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go_p,
    input  logic end_p,
    input  logic stop_p,
    input  logic abort_p,
    input  logic atn_p,
    output logic cmpl_evt
);
    dma_state_t state_q, state_d;
    logic       term;

    assign term = end_p || stop_p || abort_p || atn_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DMA_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        cmpl_evt = 1'b0;
        unique case (state_q)
            DMA_IDLE: if (go_p) state_d = DMA_RUN;
            DMA_RUN: if (term) begin
                state_d  = DMA_IDLE;
                cmpl_evt = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/irqh_sticky.sv
module irqh_sticky #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_v,
    input  logic [W-1:0] clr_v,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q[i] <= 1'b0;
            else if (set_v[i]) q[i] <= 1'b1;
            else if (clr_v[i]) q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_status_hub.sv
module irq_status_hub
    import irqh_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start_p,
    input  logic             cmd_done_p,
    input  logic             abort_cmd_p,
    input  logic             atn_p,
    input  logic             dma_go_p,
    input  logic             dma_end_p,
    input  logic             dma_stop_p,
    input  logic             auto_en,
    input  logic             auto_done_p,
    input  logic             sub1_pend,
    input  logic             sub2_pend,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] status_o,
    output logic [REG_W-1:0] mask_o,
    output logic             irq_o
);
    logic busy, done_evt, abort_evt, dma_evt;
    logic status_wr;
    logic [N_STICK-1:0] set_v, clr_v, stick_q;
    logic [REG_W-1:0]   mask_q;

    irqh_cmd_fsm u_cmd (
        .clk(clk), .rst_n(rst_n), .start_p(cmd_start_p), .done_p(cmd_done_p),
        .abort_p(abort_cmd_p), .atn_p(atn_p), .busy(busy),
        .done_evt(done_evt), .abort_evt(abort_evt)
    );

    irqh_dma_fsm u_dma (
        .clk(clk), .rst_n(rst_n), .go_p(dma_go_p), .end_p(dma_end_p),
        .stop_p(dma_stop_p), .abort_p(abort_cmd_p), .atn_p(atn_p),
        .cmpl_evt(dma_evt)
    );

    // sticky order: [3]=done, [2]=abort, [1]=dma, [0]=auto
    assign status_wr = wr_en && !wr_sel;
    assign set_v = {done_evt, abort_evt, dma_evt, auto_en && auto_done_p};
    assign clr_v = {wr_data[B_DONE], wr_data[B_ABORT], wr_data[B_DMA], wr_data[B_AUTO]}
                   & {N_STICK{status_wr}};

    irqh_sticky #(.W(N_STICK)) u_stick (
        .clk(clk), .rst_n(rst_n), .set_v(set_v), .clr_v(clr_v), .q(stick_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                mask_q <= '0;
        else if (wr_en && wr_sel)  mask_q <= wr_data;
    end

    always_comb begin
        status_o          = '0;
        status_o[B_DONE]  = stick_q[3];
        status_o[B_ABORT] = stick_q[2];
        status_o[B_BUSY]  = busy;
        status_o[B_SUB1]  = sub1_pend;
        status_o[B_SUB2]  = sub2_pend;
        status_o[B_DMA]   = stick_q[1];
        status_o[B_AUTO]  = stick_q[0];
    end

    assign mask_o = mask_q;
    assign irq_o  = |(status_o & mask_q & IRQ_SRC);
endmodule

// File: rtl/irqh_checker.sv
module irqh_checker
    import irqh_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_start_p,
    input logic             auto_en,
    input logic             auto_done_p,
    input logic             wr_en,
    input logic             wr_sel,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] status_o,
    input logic [REG_W-1:0] mask_o,
    input logic             irq_o
);
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |-> (status_o[B_DONE] == 1'b0 && mask_o == '0));

    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start_p && !status_o[B_BUSY]) |=> status_o[B_BUSY]);

    a_r5_auto_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_en && !status_o[B_AUTO]) |=> !status_o[B_AUTO]);

    a_r7_auto_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && wr_data[B_AUTO] && !(auto_en && auto_done_p)) |=> !status_o[B_AUTO]);

    a_r9_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[B_RSVD] == 1'b0);

    a_r10_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> mask_o == $past(wr_data));

    a_r11_mask_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_o == '0) |-> !irq_o);
endmodule

bind irq_status_hub irqh_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_start_p(cmd_start_p), .auto_en(auto_en),
    .auto_done_p(auto_done_p), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .status_o(status_o), .mask_o(mask_o), .irq_o(irq_o)
);

// File: tb/sim_irq_status_hub.sv
`timescale 1ns/1ps
module sim_irq_status_hub;
    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_start_p = 0, cmd_done_p = 0, abort_cmd_p = 0, atn_p = 0;
    logic dma_go_p = 0, dma_end_p = 0, dma_stop_p = 0;
    logic auto_en = 0, auto_done_p = 0, sub1_pend = 0, sub2_pend = 0;
    logic wr_en = 0, wr_sel = 0;
    logic [7:0] wr_data = '0;
    logic [7:0] status_o, mask_o;
    logic irq_o;
    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    irq_status_hub u0 (
        .clk(clk), .rst_n(rst_n), .cmd_start_p(cmd_start_p), .cmd_done_p(cmd_done_p),
        .abort_cmd_p(abort_cmd_p), .atn_p(atn_p), .dma_go_p(dma_go_p),
        .dma_end_p(dma_end_p), .dma_stop_p(dma_stop_p), .auto_en(auto_en),
        .auto_done_p(auto_done_p), .sub1_pend(sub1_pend), .sub2_pend(sub2_pend),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .status_o(status_o), .mask_o(mask_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(); @(negedge clk); endtask

    task automatic clear_all();
        wr_en = 1; wr_sel = 0; wr_data = 8'hFF; step(); wr_en = 0;
    endtask

    task automatic wr_status(input logic [7:0] d);
        wr_en = 1; wr_sel = 0; wr_data = d; step(); wr_en = 0;
    endtask

    task automatic wr_mask(input logic [7:0] d);
        wr_en = 1; wr_sel = 1; wr_data = d; step(); wr_en = 0;
    endtask

    task automatic t_reset();
        chk("R1 status", status_o, 8'h00);
        chk("R1 mask", mask_o, 8'h00);
        chk("R1 irq", {7'b0, irq_o}, 8'h00);
    endtask

    task automatic t_cmd_normal();
        cmd_start_p = 1; step(); cmd_start_p = 0;
        chk("R2 busy", status_o, 8'h20);
        wr_mask(8'hFF);
        chk("R10 mask", mask_o, 8'hFF);
        chk("R11 busy no irq", {7'b0, irq_o}, 8'h00);
        wr_status(8'hFF);
        chk("R9 busy unwritable", status_o, 8'h20);
        cmd_done_p = 1; step(); cmd_done_p = 0;
        chk("R2 done", status_o, 8'h80);
        chk("R11 irq done", {7'b0, irq_o}, 8'h01);
        wr_status(8'h80);
        chk("R7 writeback", status_o, 8'h00);
    endtask

    task automatic t_cmd_abort();
        cmd_start_p = 1; step(); cmd_start_p = 0;
        cmd_done_p = 1; abort_cmd_p = 1; step(); cmd_done_p = 0; abort_cmd_p = 0;
        chk("R3 abort wins", status_o, 8'h40);
        clear_all();
        cmd_start_p = 1; dma_go_p = 1; step(); cmd_start_p = 0; dma_go_p = 0;
        atn_p = 1; step(); atn_p = 0;
        chk("R3 R4 atn", status_o, 8'h42);
        wr_status(8'h42);
        chk("R7 snapshot", status_o, 8'h00);
    endtask

    task automatic t_dma();
        dma_end_p = 1; dma_stop_p = 1; step(); dma_end_p = 0; dma_stop_p = 0;
        chk("R4 idle ignore", status_o, 8'h00);
        dma_go_p = 1; step(); dma_go_p = 0;
        chk("R4 running no set", status_o, 8'h00);
        dma_end_p = 1; step(); dma_end_p = 0;
        chk("R4 end", status_o, 8'h02);
        clear_all();
        dma_go_p = 1; step(); dma_go_p = 0;
        dma_stop_p = 1; step(); dma_stop_p = 0;
        chk("R4 stop", status_o, 8'h02);
        clear_all();
        dma_go_p = 1; step(); dma_go_p = 0;
        abort_cmd_p = 1; step(); abort_cmd_p = 0;
        chk("R4 abort", status_o, 8'h02);
        clear_all();
    endtask

    task automatic t_auto();
        auto_done_p = 1; step(); auto_done_p = 0;
        chk("R5 disabled", status_o, 8'h00);
        auto_en = 1; auto_done_p = 1; step(); auto_done_p = 0;
        chk("R5 enabled", status_o, 8'h01);
        cmd_start_p = 1; step(); cmd_start_p = 0;
        cmd_done_p = 1; step(); cmd_done_p = 0;
        wr_status(8'h01);
        chk("R7 zero keeps", status_o, 8'h80);
        clear_all(); auto_en = 0;
    endtask

    task automatic t_summary();
        sub1_pend = 1; #1;
        chk("R6 sub1", status_o, 8'h10);
        chk("R11 sub1 irq", {7'b0, irq_o}, 8'h01);
        step(); wr_status(8'hFF);
        chk("R9 summary", status_o, 8'h10);
        sub2_pend = 1; #1;
        chk("R6 sub2", status_o, 8'h18);
        sub1_pend = 0; sub2_pend = 0; #1;
        chk("R6 drop", status_o, 8'h00);
        step();
    endtask

    task automatic t_race();
        dma_go_p = 1; step(); dma_go_p = 0;
        dma_end_p = 1; wr_en = 1; wr_sel = 0; wr_data = 8'h02; step();
        dma_end_p = 0; wr_en = 0;
        chk("R8 set wins", status_o, 8'h02);
        clear_all();
        chk("R8 then clears", status_o, 8'h00);
    endtask

    task automatic t_irq();
        wr_mask(8'h21);
        chk("R10 mask load", mask_o, 8'h21);
        dma_go_p = 1; cmd_start_p = 1; step(); dma_go_p = 0; cmd_start_p = 0;
        dma_stop_p = 1; step(); dma_stop_p = 0;
        chk("R11 masked", {7'b0, irq_o}, 8'h00);
        auto_en = 1; auto_done_p = 1; step(); auto_done_p = 0; auto_en = 0;
        chk("R11 enabled", {7'b0, irq_o}, 8'h01);
        wr_status(8'h01);
        chk("R11 cleared", {7'b0, irq_o}, 8'h00);
        chk("R9 rsvd", {7'b0, status_o[2]}, 8'h00);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) step();
        t_reset();
        rst_n = 1; step();
        t_reset();
        t_cmd_normal();
        t_cmd_abort();
        t_dma();
        t_auto();
        t_summary();
        t_race();
        t_irq();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule